// File: doc/BRIEF.md
# RTC Shadow-Register Bus Bridge

This block lets a simple 8-bit processor bus see the registers of an external real-time-clock chip as if they were local memory. A byte-wide shadow copy of the clock chip's register bank and its general-purpose RAM is kept in flops. Processor reads are answered combinationally from that copy, so the bus never waits on the slow serial link. Processor writes land in the copy and mark it as modified.

A free-running timer splits every second into four equal phases:

- **open**: writes are accepted and the ready flag is shown.
- **grace**: writes are still accepted, but the ready flag is already withdrawn.
- **write-back**: the whole shadow is pushed to the clock chip as one block, but only if it was modified.
- **refresh**: the whole shadow is read back from the chip as one block.

Each byte of a block goes through a request/acknowledge port to a separate I2C master, with first and last markers that frame the block. Moving the bank as one block keeps the BCD time fields from rolling over partway through a copy. The processor polls a status byte to learn when it may safely write.

Top module: `rtc_shadow_bridge`

## Requirements
- R1: While bus_cs_n and bus_rd_n are both low and bus_addr is below SHADOW_BYTES, bus_dout shows the shadow byte at that address in the same cycle. Whenever a read is not active, bus_dout is 0x00.
- R2: The status byte is read at address 0x7F:
  - bit 7 is ready, set only in phase 0.
  - bit 6 is the dirty flag.
  - bits 1:0 are the phase number.
  - all other bits are 0.

  Reads of addresses SHADOW_BYTES..0x7E return 0x00. Writes to addresses at or above SHADOW_BYTES change nothing and do not set dirty.
- R3: The phase number starts at 0 after reset. It then steps 0,1,2,3,0,… and each phase lasts exactly PHASE_CYCLES clocks.
- R4: A write (bus_cs_n and bus_wr_n low for one clock edge) in phase 0 or 1 to an address below SHADOW_BYTES does two things: the shadow byte takes bus_din from the next cycle on, and the dirty flag is set.
- R5: A write made during phase 2 or 3 is ignored. The shadow byte keeps its value and dirty stays clear.
- R6: On entry to phase 2 with dirty set, exactly one write block is issued. It has SHADOW_BYTES byte requests at addresses 0,1,2,… in ascending order, with xfer_first on the first byte and xfer_last on the final byte. If dirty is clear, no write request is issued during that second.
- R7: The dirty flag clears when the final byte of the write block is acknowledged.
- R8: On entry to phase 3, one read block over addresses 0..SHADOW_BYTES-1 is issued. Each acknowledged byte replaces the shadow byte at its address with xfer_rdata.
- R9: A byte transfer is held (xfer_req high, with xfer_addr, xfer_wr and xfer_wdata stable) until xfer_ack is seen. The sequencer then moves to the next address on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Processor register address |
| bus_din | input | 8 | Processor write data |
| bus_dout | output | 8 | Processor read data, 0x00 when not reading |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| xfer_req | output | 1 | Byte transfer request to the I2C master |
| xfer_wr | output | 1 | 1 = write byte to clock chip, 0 = read byte |
| xfer_addr | output | 7 | Clock chip register address of this byte |
| xfer_wdata | output | 8 | Byte to write |
| xfer_first | output | 1 | First byte of a block |
| xfer_last | output | 1 | Last byte of a block |
| xfer_ack | input | 1 | Master has finished the current byte |
| xfer_rdata | input | 8 | Byte read from the clock chip, valid with xfer_ack |

## Verification
The bench builds the block with PHASE_CYCLES set to 256 and keeps the default 96-byte shadow. A full second then lasts 1024 clocks, so several complete schedules fit in a short run. This covers a clean second with the write-back skipped, a dirty second with a full 96-byte write block, and the refresh that follows it. The bench's clock-chip model acknowledges every byte on the second cycle. That leaves a 192-cycle block inside a 256-cycle phase, so every phase boundary and every first/last marker can be observed exactly.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [1:0] {
    PH_OPEN    = 2'd0,
    PH_GRACE   = 2'd1,
    PH_WBACK   = 2'd2,
    PH_REFRESH = 2'd3
  } phase_e;

  // Status byte layout: ready in bit 7, dirty in bit 6, phase in bits 1:0
  function automatic logic [7:0] pack_status(input phase_e ph, input logic dirty);
    pack_status = {(ph == PH_OPEN), dirty, 4'b0000, ph};
  endfunction

  // The processor may modify the shadow only in the first two phases
  function automatic logic write_window(input phase_e ph);
    write_window = (ph == PH_OPEN) || (ph == PH_GRACE);
  endfunction

  function automatic logic in_shadow(input int unsigned addr, input int unsigned depth);
    in_shadow = addr < depth;
  endfunction

endpackage

// File: rtl/rsb_phase_timer.sv
module rsb_phase_timer
  import rsb_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 6_250_000
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   phase_enter
);
  localparam int unsigned CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  phase_e        phase_q;
  logic          enter_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_OPEN;
      enter_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= phase_e'(phase_q + 2'd1);
      enter_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      enter_q <= 1'b0;
    end
  end

  assign phase       = phase_q;
  assign phase_enter = enter_q;

  assert_phase_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_enter |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));

  assert_phase_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_enter |-> $stable(phase_q));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);

endmodule

// File: rtl/rsb_shadow_bank.sv
module rsb_shadow_bank #(
  parameter int unsigned DEPTH = 96,
  parameter int unsigned IW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic [IW-1:0] cpu_idx,
  input  logic [7:0]    cpu_wdata,
  input  logic          fill_we,
  input  logic [IW-1:0] fill_idx,
  input  logic [7:0]    fill_data,
  input  logic [IW-1:0] rd_idx_a,
  output logic [7:0]    rd_data_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [7:0]    rd_data_b
);
  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit_cpu, hit_fill;
    assign hit_cpu  = cpu_we  && (cpu_idx  == IW'(g));
    assign hit_fill = fill_we && (fill_idx == IW'(g));
    // A processor write wins over a refresh byte at the same address
    always_ff @(posedge clk) begin
      if (!rst_n)        mem[g] <= 8'h00;
      else if (hit_cpu)  mem[g] <= cpu_wdata;
      else if (hit_fill) mem[g] <= fill_data;
    end
  end

  assign rd_data_a = (int'(rd_idx_a) < DEPTH) ? mem[rd_idx_a] : 8'h00;
  assign rd_data_b = (int'(rd_idx_b) < DEPTH) ? mem[rd_idx_b] : 8'h00;

  assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !(cpu_we && cpu_idx == fill_idx) && int'(fill_idx) < DEPTH)
      |=> (mem[$past(fill_idx)] == $past(fill_data)));

endmodule

// File: rtl/rsb_xfer_seq.sv
module rsb_xfer_seq #(
  parameter int unsigned DEPTH = 96,
  parameter int unsigned IW    = 7,
  parameter int unsigned AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wb,
  input  logic          start_rd,
  input  logic [7:0]    shadow_byte,
  output logic [IW-1:0] cur_idx,
  output logic          xfer_req,
  output logic          xfer_wr,
  output logic [AW-1:0] xfer_addr,
  output logic [7:0]    xfer_wdata,
  output logic          xfer_first,
  output logic          xfer_last,
  input  logic          xfer_ack,
  input  logic [7:0]    xfer_rdata,
  output logic          fill_we,
  output logic [7:0]    fill_data,
  output logic          wb_done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  logic          busy_q, wr_q, rd_pend_q;
  logic [IW-1:0] idx_q;
  logic          at_last, byte_done;

  assign at_last   = (idx_q == LAST_IDX);
  assign byte_done = busy_q && xfer_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      wr_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      idx_q     <= '0;
    end else if (!busy_q) begin
      if (start_wb) begin
        busy_q <= 1'b1;
        wr_q   <= 1'b1;
        idx_q  <= '0;
      end else if (start_rd || rd_pend_q) begin
        busy_q    <= 1'b1;
        wr_q      <= 1'b0;
        idx_q     <= '0;
        rd_pend_q <= 1'b0;
      end
    end else begin
      // A refresh request that meets a running block waits for it
      if (start_rd) rd_pend_q <= 1'b1;
      if (byte_done) begin
        if (at_last) busy_q <= 1'b0;
        else         idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign cur_idx    = idx_q;
  assign xfer_req   = busy_q;
  assign xfer_wr    = busy_q && wr_q;
  assign xfer_addr  = AW'(idx_q);
  assign xfer_wdata = shadow_byte;
  assign xfer_first = busy_q && (idx_q == '0);
  assign xfer_last  = busy_q && at_last;
  assign fill_we    = byte_done && !wr_q;
  assign fill_data  = xfer_rdata;
  assign wb_done    = byte_done && wr_q && at_last;

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_wr)));

  assert_advance_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !xfer_last) |=> (xfer_req && xfer_addr == $past(xfer_addr) + 1'b1));

  assert_block_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_first, xfer_last}));

  assert_addr_in_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (int'(xfer_addr) < DEPTH));

endmodule

// File: rtl/rtc_shadow_bridge.sv
module rtc_shadow_bridge
  import rsb_pkg::*;
#(
  parameter int unsigned PHASE_CYCLES = 6_250_000,
  parameter int unsigned SHADOW_BYTES = 96,
  parameter int unsigned AW           = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_din,
  output logic [7:0]    bus_dout,
  input  logic          bus_cs_n,
  input  logic          bus_wr_n,
  input  logic          bus_rd_n,
  output logic          xfer_req,
  output logic          xfer_wr,
  output logic [AW-1:0] xfer_addr,
  output logic [7:0]    xfer_wdata,
  output logic          xfer_first,
  output logic          xfer_last,
  input  logic          xfer_ack,
  input  logic [7:0]    xfer_rdata
);
  localparam int unsigned   IW          = $clog2(SHADOW_BYTES);
  localparam logic [AW-1:0] STATUS_ADDR = {AW{1'b1}};

  phase_e        phase;
  logic          phase_enter;
  logic          dirty_q;
  logic          cpu_rd, cpu_wr, cpu_wr_accept, addr_in_bank;
  logic          start_wb, start_rd, fill_we, wb_done;
  logic [IW-1:0] seq_idx;
  logic [7:0]    fill_data, seq_byte, cpu_byte;

  rsb_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_enter(phase_enter)
  );

  assign addr_in_bank  = in_shadow(int'(bus_addr), SHADOW_BYTES);
  assign cpu_rd        = !bus_cs_n && !bus_rd_n;
  assign cpu_wr        = !bus_cs_n && !bus_wr_n;
  assign cpu_wr_accept = cpu_wr && addr_in_bank && write_window(phase);

  assign start_wb = phase_enter && (phase == PH_WBACK) && dirty_q;
  assign start_rd = phase_enter && (phase == PH_REFRESH);

  rsb_shadow_bank #(.DEPTH(SHADOW_BYTES), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_wr_accept), .cpu_idx(IW'(bus_addr)), .cpu_wdata(bus_din),
    .fill_we(fill_we), .fill_idx(seq_idx), .fill_data(fill_data),
    .rd_idx_a(IW'(bus_addr)), .rd_data_a(cpu_byte),
    .rd_idx_b(seq_idx), .rd_data_b(seq_byte)
  );

  rsb_xfer_seq #(.DEPTH(SHADOW_BYTES), .IW(IW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_wb(start_wb), .start_rd(start_rd), .shadow_byte(seq_byte),
    .cur_idx(seq_idx),
    .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_first(xfer_first), .xfer_last(xfer_last),
    .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata),
    .fill_we(fill_we), .fill_data(fill_data), .wb_done(wb_done)
  );

  // A new modification wins over completion of an older write-back
  always_ff @(posedge clk) begin
    if (!rst_n)             dirty_q <= 1'b0;
    else if (cpu_wr_accept) dirty_q <= 1'b1;
    else if (wb_done)       dirty_q <= 1'b0;
  end

  always_comb begin
    bus_dout = 8'h00;
    if (cpu_rd) begin
      if (bus_addr == STATUS_ADDR) bus_dout = pack_status(phase, dirty_q);
      else if (addr_in_bank)       bus_dout = cpu_byte;
    end
  end

  assert_dirty_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_accept |=> dirty_q);

  assert_closed_write_no_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !write_window(phase) && !dirty_q) |=> !dirty_q);

  assert_wb_needs_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_wr) |-> dirty_q);

  assert_clean_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && !cpu_wr_accept) |=> !dirty_q);

  assert_idle_dout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> (bus_dout == 8'h00));

endmodule

// File: tb/tb_rtc_shadow_bridge.sv
module tb_rtc_shadow_bridge;
  localparam int PC = 256;
  localparam int NB = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic       xfer_req, xfer_wr, xfer_first, xfer_last;
  logic [6:0] xfer_addr;
  logic [7:0] xfer_wdata;
  logic       xfer_ack = 1'b0;
  logic [7:0] xfer_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] chip [NB];
  int wr_bytes = 0, wr_firsts = 0, wr_lasts = 0, order_err = 0, exp_addr = 0;

  always #2 clk = ~clk;

  rtc_shadow_bridge #(.PHASE_CYCLES(PC), .SHADOW_BYTES(NB), .AW(7)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_first(xfer_first), .xfer_last(xfer_last),
    .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata)
  );

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  // Clock-chip model: acknowledges each held request on alternate cycles
  initial begin
    for (int i = 0; i < NB; i++) chip[i] = pattern(i);
    forever begin
      @(negedge clk);
      if (rst_n && xfer_req && !xfer_ack) begin
        xfer_ack = 1'b1;
        if (xfer_wr) begin
          if (xfer_first) begin wr_firsts++; exp_addr = 0; end
          if (int'(xfer_addr) != exp_addr) order_err++;
          exp_addr++;
          chip[xfer_addr] = xfer_wdata;
          wr_bytes++;
          if (xfer_last) wr_lasts++;
        end else begin
          xfer_rdata = chip[xfer_addr];
        end
      end else begin
        xfer_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    #1 d = bus_dout;
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_din = v; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  task automatic wait_phase(input int p);
    logic [7:0] s;
    for (int n = 0; n < 4 * PC + 8; n++) begin
      bus_read(7'h7F, s);
      if (int'(s[1:0]) == p) return;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    #1 chk("R1 idle dout", int'(bus_dout), 0);
    bus_read(7'h7F, d);
    chk("R2 status after reset", int'(d), 8'h80);
    bus_read(7'h05, d);
    chk("R1 shadow after reset", int'(d), 0);
    bus_read(7'h70, d);
    chk("R2 unused address reads 0", int'(d), 0);
  endtask

  task automatic t_schedule;
    logic [7:0] s, d;
    int base = wr_bytes;
    wait_phase(1);
    for (int p = 1; p < 4; p++) begin
      int n = 0;
      s = 8'(p);
      while (int'(s[1:0]) == p && n < 2 * PC) begin
        n++;
        bus_read(7'h7F, s);
        if (int'(s[1:0]) == p) chk("R2 ready only in phase 0", int'(s[7]), 0);
      end
      chk($sformatf("R3 phase %0d length", p), n, PC);
    end
    chk("R3 wraps to phase 0 with ready", int'(s), 8'h80);
    chk("R6 no write block when clean", wr_bytes - base, 0);
    for (int i = 0; i < NB; i++) begin
      bus_read(7'(i), d);
      chk($sformatf("R8 refresh byte %0d", i), int'(d), int'(pattern(i)));
    end
  endtask

  task automatic t_write_and_writeback;
    logic [7:0] d;
    int b0, f0, l0;
    bus_write(7'h05, 8'hA5);
    bus_read(7'h05, d);
    chk("R4 write in phase 0", int'(d), 8'hA5);
    bus_read(7'h7F, d);
    chk("R4 dirty set", int'(d), 8'hC0);
    wait_phase(1);
    bus_write(7'h40, 8'h3C);
    bus_read(7'h40, d);
    chk("R4 write in grace phase", int'(d), 8'h3C);
    b0 = wr_bytes; f0 = wr_firsts; l0 = wr_lasts;
    wait_phase(3);
    chk("R6 block byte count", wr_bytes - b0, NB);
    chk("R6 one first marker", wr_firsts - f0, 1);
    chk("R6 one last marker", wr_lasts - l0, 1);
    chk("R6 ascending addresses", order_err, 0);
    chk("R6 chip got byte 0x05", int'(chip[5]), 8'hA5);
    chk("R6 chip got byte 0x40", int'(chip[64]), 8'h3C);
    bus_read(7'h7F, d);
    chk("R7 dirty cleared after block", int'(d[6]), 0);
    wait_phase(0);
    bus_read(7'h05, d);
    chk("R8 refresh confirms 0x05", int'(d), 8'hA5);
    bus_read(7'h06, d);
    chk("R8 refresh keeps neighbour", int'(d), int'(pattern(6)));
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    int b0;
    bus_write(7'h65, 8'hFF);
    bus_read(7'h65, d);
    chk("R2 write above shadow ignored", int'(d), 0);
    bus_read(7'h7F, d);
    chk("R2 no dirty from unused address", int'(d[6]), 0);
    wait_phase(2);
    b0 = wr_bytes;
    bus_write(7'h07, 8'h55);
    bus_read(7'h07, d);
    chk("R5 write in phase 2 ignored", int'(d), int'(pattern(7)));
    bus_read(7'h7F, d);
    chk("R5 no dirty in phase 2", int'(d[6]), 0);
    wait_phase(3);
    bus_write(7'h08, 8'h99);
    bus_read(7'h08, d);
    chk("R5 write in phase 3 ignored", int'(d), int'(pattern(8)));
    bus_read(7'h7F, d);
    chk("R5 no dirty in phase 3", int'(d[6]), 0);
    wait_phase(0);
    chk("R6 clean second sends nothing", wr_bytes - b0, 0);
    chk("R5 chip untouched", int'(chip[7]), int'(pattern(7)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_schedule();
    t_write_and_writeback();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule